// File: doc/BRIEF.md
# Flash Write Completion Poller

This block sits on the host side of a parallel NOR flash bus. Once software or a sequencer has issued a program or erase command, the block takes over the bus. It repeatedly reads one address until the device reports that its internal write has finished. It then verifies the stored byte and reports done, pass or fail, and timeout.

The device reports progress only through the data it returns on reads. Two detection methods are offered, selected at start:

- **Complement method.** While the device is busy, bit 7 reads as the inverse of its final value. It reads the true value once the write has finished.
- **Toggle method.** While the device is busy, bit 6 flips on every read. It holds steady once the write has finished.

When bit 7 first shows its final value, the lower bits may still be unsettled. The block therefore waits a settle interval before it reads the whole byte. A completion edge can fall between reads and give a misleading result, so a mismatching byte is read twice more before the operation is rejected. A per-operation clock budget bounds the whole run.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, busy, done, pass and timeout are 0, and both read strobes (rd_ce_n, rd_oe_n) are high.
- R2: Every read drives rd_ce_n and rd_oe_n low together for exactly ACC_CYC clocks, with rd_addr equal to the target captured at start. The data is sampled at the end of the last of those clocks, and both strobes then return high for at least one clock.
- R3: With use_toggle=0, completion is seen when bit 7 of a read equals bit 7 of the final byte. The final byte is exp_byte for op_kind 0 (program) and FFh for op_kind 1 (sector/block erase), 2 or 3 (chip erase).
- R4: With use_toggle=1, completion is seen when two consecutive reads return the same bit 6.
- R5: After completion is seen, the strobes stay high for SETTLE_CYC clocks. A full read then follows. If that byte equals the final byte, done=1 and pass=1.
- R6: If that full read mismatches, two further reads follow. Pass requires both of them to match. Otherwise the result is done=1, pass=0, timeout=0.
- R7: If no result is reached, done=1, timeout=1 and pass=0 appear exactly N clocks after the start edge. N is TO_PROG for op_kind 0, TO_BLK for 1, and TO_CHIP for 2 and 3. A result reached earlier never sets timeout.
- R8: A start pulse while busy is ignored. The running operation keeps its address, op_kind, method and expected byte, and it ends with the outcome it would otherwise have had.
- R9: An accepted start clears done, pass and timeout, and raises busy on the next clock. The result flags then hold until the next accepted start, with busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling; accepted only while idle |
| op_kind | input | 2 | 0 program, 1 sector/block erase, 2 or 3 chip erase |
| use_toggle | input | 1 | 0 complement method, 1 toggle method |
| tgt_addr | input | AW | Address to poll |
| exp_byte | input | 8 | Byte written by a program operation |
| rd_addr | output | AW | Flash address |
| rd_ce_n | output | 1 | Flash chip enable, active low |
| rd_oe_n | output | 1 | Flash output enable, active low |
| rd_data | input | 8 | Flash read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result available |
| pass | output | 1 | Verified byte matched |
| timeout | output | 1 | Clock budget ran out |

## Verification
A cycle-level flash model in the bench returns complemented or zero bit 7 and a flipping bit 6 while busy. It returns junk low bits for a stale window after finishing, and then the stored byte. The main function is swept over both methods, every op_kind and expected bytes with bit 7 both set and clear. This separates the program and erase polarity of bit 7 and confirms that exp_byte is ignored for erases.

All eight patterns of corrupted reads across the verify read and the two rechecks are applied. This tells apart a block that rejects on the first bad read from one that needs two confirmations. A stored byte that really differs shows a genuine failure. Busy times beyond each budget pin the exact timeout cycle for every op_kind. A mid-run start with different operands shows that such a pulse is ignored.

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int AW         = 21,
  parameter int ACC_CYC    = 3,
  parameter int SETTLE_CYC = 50,
  parameter int TO_PROG    = 1000,
  parameter int TO_BLK     = 1250000,
  parameter int TO_CHIP    = 5000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op_kind,
  input  logic          use_toggle,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    exp_byte,
  output logic [AW-1:0] rd_addr,
  output logic          rd_ce_n,
  output logic          rd_oe_n,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          timeout
);
  localparam int TO_MAX = (TO_PROG > TO_BLK) ? ((TO_PROG > TO_CHIP) ? TO_PROG : TO_CHIP)
                                             : ((TO_BLK > TO_CHIP) ? TO_BLK : TO_CHIP);
  localparam int TW = $clog2(TO_MAX + 1);
  localparam int CW = $clog2(ACC_CYC + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_POLL, ST_SETTLE, ST_VERIFY, ST_RECHK} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [7:0]    want_q;
  logic [1:0]    op_q;
  logic          tog_q;
  logic [CW-1:0] acc_cnt;
  logic          gap;
  logic [SW-1:0] set_cnt;
  logic [TW-1:0] tmo_cnt;
  logic [TW-1:0] tmo_lim;
  logic          prev6, have_prev, rck_second;

  wire reading  = (st == ST_POLL) || (st == ST_VERIFY) || (st == ST_RECHK);
  wire strobe   = reading && !gap;
  wire fire     = strobe && (acc_cnt == CW'(ACC_CYC - 1));
  wire match    = (rd_data == want_q);
  wire seen     = tog_q ? (have_prev && (rd_data[6] == prev6)) : (rd_data[7] == want_q[7]);
  wire fin_pass = fire && match && ((st == ST_VERIFY) || (st == ST_RECHK && rck_second));
  wire fin_fail = fire && !match && (st == ST_RECHK);
  wire expired  = busy && (tmo_cnt == tmo_lim - 1'b1);

  assign tmo_lim = (op_q == 2'd0) ? TW'(TO_PROG) : (op_q == 2'd1) ? TW'(TO_BLK) : TW'(TO_CHIP);
  assign rd_addr = addr_q;
  assign rd_ce_n = !strobe;
  assign rd_oe_n = !strobe;
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      addr_q     <= '0;
      want_q     <= '0;
      op_q       <= '0;
      tog_q      <= 1'b0;
      acc_cnt    <= '0;
      gap        <= 1'b0;
      set_cnt    <= '0;
      tmo_cnt    <= '0;
      prev6      <= 1'b0;
      have_prev  <= 1'b0;
      rck_second <= 1'b0;
      done       <= 1'b0;
      pass       <= 1'b0;
      timeout    <= 1'b0;
    end else if (st == ST_IDLE) begin
      if (start) begin
        st        <= ST_POLL;
        addr_q    <= tgt_addr;
        want_q    <= (op_kind == 2'd0) ? exp_byte : 8'hFF;
        op_q      <= op_kind;
        tog_q     <= use_toggle;
        acc_cnt   <= '0;
        gap       <= 1'b0;
        tmo_cnt   <= '0;
        have_prev <= 1'b0;
        done      <= 1'b0;
        pass      <= 1'b0;
        timeout   <= 1'b0;
      end
    end else begin
      tmo_cnt <= tmo_cnt + 1'b1;
      if (gap) gap <= 1'b0;
      else if (fire) begin
        gap     <= 1'b1;
        acc_cnt <= '0;
      end else if (strobe) acc_cnt <= acc_cnt + 1'b1;

      if (fin_pass || fin_fail) begin
        st   <= ST_IDLE;
        done <= 1'b1;
        pass <= fin_pass;
      end else if (expired) begin
        st      <= ST_IDLE;
        done    <= 1'b1;
        timeout <= 1'b1;
      end else begin
        unique case (st)
          ST_POLL: if (fire) begin
            prev6     <= rd_data[6];
            have_prev <= 1'b1;
            if (seen) begin
              st      <= ST_SETTLE;
              set_cnt <= '0;
            end
          end
          ST_SETTLE: begin
            set_cnt <= set_cnt + 1'b1;
            if (set_cnt == SW'(SETTLE_CYC - 1)) st <= ST_VERIFY;
          end
          ST_VERIFY: if (fire) begin
            st         <= ST_RECHK;
            rck_second <= 1'b0;
          end
          ST_RECHK: if (fire) rck_second <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_done_poller_chk.sv
module flash_done_poller_chk #(
  parameter int AW      = 21,
  parameter int ACC_CYC = 3,
  parameter int TO_MAX  = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          timeout,
  input logic          rd_oe_n,
  input logic [AW-1:0] rd_addr
);
  localparam int LW = $clog2(ACC_CYC + 2);
  localparam int BW = $clog2(TO_MAX + 2);

  logic [LW-1:0] low_run;
  logic [BW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run  <= '0;
      busy_run <= '0;
    end else begin
      low_run  <= rd_oe_n ? '0 : low_run + 1'b1;
      busy_run <= busy ? busy_run + 1'b1 : '0;
    end
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> rd_oe_n);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_oe_n && $past(!rd_oe_n)) |-> $stable(rd_addr));
  p_access_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_oe_n) && !done) |-> (low_run == LW'(ACC_CYC)));
  p_timeout_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (done && !pass));
  p_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < BW'(TO_MAX)));
  p_keep_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_addr));
  p_take_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !timeout && !pass));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind flash_done_poller flash_done_poller_chk #(.AW(AW), .ACC_CYC(ACC_CYC), .TO_MAX(TO_MAX)) u_fdp_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
  .timeout(timeout), .rd_oe_n(rd_oe_n), .rd_addr(rd_addr)
);

// File: tb/flash_done_poller_bench.sv
module flash_done_poller_bench;
  localparam int AW = 8, ACC = 3, SETTLE = 12, STALE = 10;
  localparam int TOP = 200, TOB = 400, TOC = 600;
  localparam logic [AW-1:0] TGT = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] i_op = '0;
  logic i_meth = 1'b0;
  logic [7:0] i_exp = '0;
  logic [AW-1:0] rd_addr;
  logic rd_ce_n, rd_oe_n, busy, done, pass, timeout;
  logic [7:0] mdata;

  always #10 clk = ~clk;

  flash_done_poller #(.AW(AW), .ACC_CYC(ACC), .SETTLE_CYC(SETTLE), .TO_PROG(TOP),
                      .TO_BLK(TOB), .TO_CHIP(TOC)) u_flash_done_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(i_op), .use_toggle(i_meth),
    .tgt_addr(TGT), .exp_byte(i_exp), .rd_addr(rd_addr), .rd_ce_n(rd_ce_n),
    .rd_oe_n(rd_oe_n), .rd_data(mdata), .busy(busy), .done(done), .pass(pass),
    .timeout(timeout));

  // flash model
  logic [15:0] cfg_busy = '0;
  logic [7:0]  cfg_true = '0, cfg_exp = '0;
  logic        cfg_prog = 1'b0;
  logic [2:0]  cfg_mask = '0;
  logic [15:0] busy_left, post;
  logic        tog, oe_q;
  logic [3:0]  low_cnt;
  logic [2:0]  ridx;
  int          addr_bad, run_bad, pair_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_left <= '0; post <= 16'hFFFF; tog <= 1'b0; oe_q <= 1'b1;
      low_cnt <= '0; ridx <= '0; addr_bad <= 0; run_bad <= 0; pair_bad <= 0;
    end else begin
      oe_q    <= rd_oe_n;
      low_cnt <= rd_oe_n ? 4'd0 : low_cnt + 4'd1;
      if (!rd_oe_n && rd_addr != TGT) addr_bad <= addr_bad + 1;
      if (rd_ce_n != rd_oe_n) pair_bad <= pair_bad + 1;
      if (!oe_q && rd_oe_n) begin
        if (!done && low_cnt != 4'(ACC)) run_bad <= run_bad + 1;
        if (busy_left != 0) tog <= ~tog;
        else if (post >= 16'(STALE) && ridx < 3'd3) ridx <= ridx + 3'd1;
      end
      if (start && !busy) begin
        busy_left <= cfg_busy; post <= '0; ridx <= '0;
      end else if (busy_left != 0) busy_left <= busy_left - 16'd1;
      else if (post != 16'hFFFF) post <= post + 16'd1;
    end
  end

  always_comb begin
    if (int'(low_cnt) < ACC - 1) mdata = 8'hC3;
    else if (busy_left != 0) mdata = {cfg_prog ? ~cfg_exp[7] : 1'b0, tog, 6'b010101};
    else if (post < 16'(STALE)) mdata = {cfg_true[7], tog, 6'b010101};
    else mdata = cfg_true ^ {7'b0, (ridx < 3'd3) && cfg_mask[ridx[1:0]]};
  end

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run_op(input bit meth, input logic [1:0] op, input logic [7:0] ex,
                        input logic [7:0] tru, input int bsy, input logic [2:0] mask,
                        input bit want_pass, input bit want_to, input bit inject,
                        input string req);
    int n;
    @(negedge clk);
    cfg_busy = 16'(bsy); cfg_true = tru; cfg_exp = ex; cfg_prog = (op == 2'd0); cfg_mask = mask;
    i_meth = meth; i_op = op; i_exp = ex; start = 1'b1;
    @(posedge clk); #1;
    chk(busy && !done && !timeout && !pass, "R9 start taken", {busy, done, timeout}, 3'b100);
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 3000) begin
      @(posedge clk); n++; #1;
      if (inject && n == 7) begin
        @(negedge clk);
        i_meth = ~meth; i_op = 2'd2; i_exp = 8'h55; start = 1'b1;
        @(negedge clk); start = 1'b0;
        n += 1;
      end
    end
    chk(done, {req, " done"}, done, 1);
    chk(pass == want_pass, {req, " pass"}, pass, want_pass);
    chk(timeout == want_to, {req, " timeout"}, timeout, want_to);
    if (want_to) chk(n == ((op == 2'd0) ? TOP : (op == 2'd1) ? TOB : TOC), "R7 timeout cycle", n,
                     (op == 2'd0) ? TOP : (op == 2'd1) ? TOB : TOC);
    repeat (4) @(posedge clk);
    #1 chk(done && !busy && rd_ce_n && rd_oe_n && pass == want_pass, "R9 result held",
           {done, busy, pass}, {1'b1, 1'b0, want_pass});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] pats [6] = '{8'h00, 8'h3C, 8'h7F, 8'h80, 8'hA5, 8'hFF};
    repeat (3) @(posedge clk);
    #1 chk(!busy && !done && !pass && !timeout && rd_ce_n && rd_oe_n, "R1 reset state",
           {busy, done, pass, timeout, rd_ce_n, rd_oe_n}, 6'b000011);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 6; p++)
        run_op(m[0], 2'd0, pats[p], pats[p], 20 + 7 * p, 3'b000, 1'b1, 1'b0, 1'b0,
               m[0] ? "R4 program toggle" : "R3 program complement");
      for (int o = 1; o < 4; o++)
        run_op(m[0], 2'(o), 8'h12, 8'hFF, 25 + 9 * o, 3'b000, 1'b1, 1'b0, 1'b0,
               m[0] ? "R4 erase toggle" : "R3 erase complement");
    end
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 8; k++)
        run_op(m[0], 2'd0, 8'h3C, 8'h3C, 30, 3'(k),
               !k[0] || (!k[1] && !k[2]), 1'b0, 1'b0, "R6 recheck pattern");
    for (int m = 0; m < 2; m++)
      run_op(m[0], 2'd0, 8'h3C, 8'h38, 30, 3'b000, 1'b0, 1'b0, 1'b0, "R5 stored byte differs");
    run_op(1'b0, 2'd1, 8'h00, 8'hFF, 40, 3'b000, 1'b1, 1'b0, 1'b0, "R5 settle then verify");
    for (int o = 0; o < 4; o++)
      run_op(1'b0, 2'(o), 8'h3C, 8'h3C, 5000, 3'b000, 1'b0, 1'b1, 1'b0, "R7 timeout");
    run_op(1'b1, 2'd0, 8'h3C, 8'h3C, 40, 3'b000, 1'b1, 1'b0, 1'b1, "R8 start ignored while busy");
    chk(addr_bad == 0, "R2 address during read", addr_bad, 0);
    chk(run_bad == 0, "R2 access length", run_bad, 0);
    chk(pair_bad == 0, "R2 strobes together", pair_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule